// File: doc/BRIEF.md
# Full-Duplex Byte SPI Master

This block drives a serial peripheral bus as the master, one byte at a time. The host places a byte into a single-entry transmit holding register. The controller moves that byte into an output shift register and clocks it out MSB first. On the same serial clock edges it shifts the byte coming back from the peripheral into a separate input shift register. Each byte that goes out therefore brings one byte back, which lands in a single-entry receive holding register. To fetch a response only, the host sends a filler byte, normally 0x00.

The bus runs in mode 0. The serial clock idles low, the peripheral's data is sampled on the rising edge and the outgoing bit changes on the falling edge. A divider input sets how many system clocks each serial clock half-period lasts. Chip select goes low when the first byte starts. It stays low across any number of bytes until the host asks for it to be released, so a command byte and its reply bytes can form one transaction. A byte the host writes while another is shifting waits in the holding register and follows without a gap. A received byte that arrives while the previous one is still unread is dropped. It raises a sticky overrun flag that halts all shifting until the host clears it.

Top module: `spi_duplex_master`

## Requirements
- R1: After reset, and whenever the bus is idle with chip select released, `cs_n` is 1 and `sclk` is 0. After reset `tx_empty` is 1, `rx_full` is 0 and `overrun` is 0. `sclk` is never 1 while `cs_n` is 1.
- R2: Mode 0 with MSB first. `mosi` carries bit 7 of the byte before the first rising `sclk`, and it changes only while `sclk` is 0. `miso` is sampled on each rising `sclk`, and the first sampled bit becomes bit 7 of the received byte.
- R3: A pulse on `wr_en` while `tx_empty` is 1 captures `wr_data`, and `tx_empty` reads 0 in the following cycle. When the controller is idle, the byte moves to the shifter one cycle later and `tx_empty` returns to 1.
- R4: Every transmitted byte yields one received byte on `rd_data`, with `rx_full` set to 1. A pulse on `rd_en` clears `rx_full`.
- R5: Each `sclk` half-period lasts `div_i + 1` system clock cycles, so the rising edges are `2*(div_i+1)` cycles apart.
- R6: A byte written while another is shifting starts right after it. The rising-edge spacing across the byte boundary stays `2*(div_i+1)`, and `cs_n` stays 0 between the two bytes.
- R7: A `cs_release` pulse while a byte is shifting takes effect only when that byte's eighth falling edge is reached. `cs_n` stays 0 until then and never rises part-way through a byte. When idle, `cs_n` goes to 1 in the next cycle.
- R8: A byte that completes while `rx_full` is 1 sets `overrun` and is dropped, and `rd_data` keeps the earlier byte. `overrun` stays 1 until `ovr_clr` is pulsed, even if the host reads.
- R9: While `overrun` is 1, no byte starts and `sclk` stays 0. A byte already held in the transmit register waits and begins after `ovr_clr`.
- R10: A `wr_en` pulse while `tx_empty` is 0 is ignored: the held byte is not replaced and no extra byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Serial clock half-period minus one, in system clocks |
| wr_en | input | 1 | Host write strobe for the transmit register |
| wr_data | input | FRAME_W | Byte to transmit |
| tx_empty | output | 1 | Transmit register can take a byte |
| rd_en | input | 1 | Host read strobe, clears the receive-full flag |
| rd_data | output | FRAME_W | Last received byte |
| rx_full | output | 1 | An unread received byte is present |
| cs_release | input | 1 | Request to raise chip select after the current byte |
| ovr_clr | input | 1 | Clears the overrun error |
| overrun | output | 1 | Sticky overrun error |
| busy | output | 1 | A byte is being shifted |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bound checker watches properties that hold on every cycle. The serial clock stays low while chip select is high, during an overrun and at the moment chip select rises. `mosi` holds steady while `sclk` is high. An accepted write empties and then refills the transmit flag in order, a read drops `rx_full`, and the overrun flag stays set. The bench scenarios cover what needs a peripheral model or a whole transfer to see. These are the byte values in both directions, the exact half-period for several divider settings, gapless back-to-back bytes under one chip select, a deferred release landing on a byte boundary, and a held byte resuming after the error clears.

// File: rtl/spi_dm_pkg.sv
package spi_dm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LOW  = 2'b01,
        ST_HIGH = 2'b11
    } xfer_state_e;
endpackage

// File: rtl/spi_dm_clkdiv.sv
module spi_dm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    // tick marks the last cycle of each half-period
    always_comb begin
        tick  = run && (cnt_q == div_i);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_dm_shifter.sv
module spi_dm_shifter #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_data,
    input  logic               rise,
    input  logic               fall,
    input  logic               miso,
    output logic               mosi,
    output logic [FRAME_W-1:0] rx_byte
);
    typedef struct packed {
        logic [FRAME_W-1:0] tx_sh;
        logic [FRAME_W-1:0] rx_sh;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d = q;
        if (rise) begin
            d.rx_sh = {q.rx_sh[FRAME_W-2:0], miso};
        end
        if (load) begin
            d.tx_sh = load_data;
        end else if (fall) begin
            d.tx_sh = {q.tx_sh[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mosi    = q.tx_sh[FRAME_W-1];
    assign rx_byte = q.rx_sh;
endmodule

// File: rtl/spi_duplex_master.sv
module spi_duplex_master
    import spi_dm_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   div_i,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    output logic               tx_empty,
    input  logic               rd_en,
    output logic [FRAME_W-1:0] rd_data,
    output logic               rx_full,
    input  logic               cs_release,
    input  logic               ovr_clr,
    output logic               overrun,
    output logic               busy,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic               cs_n
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        xfer_state_e        st;
        logic [CNT_W-1:0]   bitcnt;
        logic               cs_n;
        logic               rel_pend;
        logic [FRAME_W-1:0] tx_data;
        logic               tx_full;
        logic [FRAME_W-1:0] rx_data;
        logic               rx_full;
        logic               ovr;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:       ST_IDLE,
        bitcnt:   '0,
        cs_n:     1'b1,
        rel_pend: 1'b0,
        tx_data:  '0,
        tx_full:  1'b0,
        rx_data:  '0,
        rx_full:  1'b0,
        ovr:      1'b0
    };

    ctl_t d, q;
    logic tick, rise, fall, load;
    logic [FRAME_W-1:0] rx_byte;

    spi_dm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st != ST_IDLE),
        .div_i (div_i),
        .tick  (tick)
    );

    spi_dm_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (q.tx_data),
        .rise      (rise),
        .fall      (fall),
        .miso      (miso),
        .mosi      (mosi),
        .rx_byte   (rx_byte)
    );

    always_comb begin
        d    = q;
        load = 1'b0;
        rise = tick && (q.st == ST_LOW);
        fall = tick && (q.st == ST_HIGH);

        // host side: read frees the receive slot before a completion looks at it
        if (rd_en) begin
            d.rx_full = 1'b0;
        end
        if (ovr_clr) begin
            d.ovr = 1'b0;
        end
        if (wr_en && !q.tx_full) begin
            d.tx_data = wr_data;
            d.tx_full = 1'b1;
        end
        if (cs_release) begin
            if (q.st != ST_IDLE) begin
                d.rel_pend = 1'b1;
            end else begin
                d.cs_n = 1'b1;
            end
        end

        // serial clock edges
        if (rise) begin
            d.st = ST_HIGH;
        end
        if (fall) begin
            d.st = ST_LOW;
            if (q.bitcnt == LAST_BIT) begin
                d.bitcnt = '0;
                if (d.rx_full) begin
                    d.ovr = 1'b1;
                end else begin
                    d.rx_data = rx_byte;
                    d.rx_full = 1'b1;
                end
                if (q.rel_pend || cs_release) begin
                    d.cs_n     = 1'b1;
                    d.rel_pend = 1'b0;
                    d.st       = ST_IDLE;
                end else if (q.tx_full && !d.ovr) begin
                    load      = 1'b1;
                    d.tx_full = 1'b0;
                end else begin
                    d.st = ST_IDLE;
                end
            end else begin
                d.bitcnt = q.bitcnt + 1'b1;
            end
        end

        // start from idle
        if (q.st == ST_IDLE && q.tx_full && !q.ovr) begin
            load      = 1'b1;
            d.tx_full = 1'b0;
            d.st      = ST_LOW;
            d.bitcnt  = '0;
            d.cs_n    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTL_RST;
        end else begin
            q <= d;
        end
    end

    assign tx_empty = !q.tx_full;
    assign rd_data  = q.rx_data;
    assign rx_full  = q.rx_full;
    assign overrun  = q.ovr;
    assign busy     = (q.st != ST_IDLE);
    assign sclk     = (q.st == ST_HIGH);
    assign cs_n     = q.cs_n;
endmodule

// File: rtl/spi_duplex_master_chk.sv
module spi_duplex_master_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic ovr_clr,
    input logic tx_empty,
    input logic rx_full,
    input logic overrun,
    input logic sclk,
    input logic mosi,
    input logic cs_n
);
    a_r1_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r2_mosi_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    a_r3_write_fills_register: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_empty) |=> !tx_empty);

    a_r4_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sclk) |=> !rx_full);

    a_r7_release_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sclk);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    a_r9_overrun_halts_clock: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !sclk);
endmodule

bind spi_duplex_master spi_duplex_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .ovr_clr  (ovr_clr),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .overrun  (overrun),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_n     (cs_n)
);

// File: tb/spi_duplex_master_bench.sv
module spi_duplex_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_i = 8'd1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       cs_release = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       tx_empty, rx_full, overrun, busy, sclk, mosi, miso, cs_n;
    logic [7:0] rd_data;

    spi_duplex_master u_spi_duplex_master (
        .clk(clk), .rst_n(rst_n), .div_i(div_i),
        .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty),
        .rd_en(rd_en), .rd_data(rd_data), .rx_full(rx_full),
        .cs_release(cs_release), .ovr_clr(ovr_clr), .overrun(overrun),
        .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int done   = 0;
    int cyc    = 0;
    int e_k    = 0;

    always @(posedge clk) cyc++;

    // peripheral model: k-th byte on the wire returns resp_of(k)
    function automatic logic [7:0] resp_of(int k);
        return 8'((k * 53 + 17) ^ (k >> 2));
    endfunction

    int         slv_k = 0;
    int         slv_bit = 0;
    logic [7:0] slv_cur = 8'h00;
    logic [7:0] cap_sh = 8'h00;
    int         cap_cnt = 0;
    logic [7:0] sent_mem [0:1023];
    int         sent_n = 0;
    int         cs_rises = 0;
    int         partial = 0;
    int         last_rise = -1;
    int         gmin = 1000000;
    int         gmax = 0;

    assign miso = slv_cur[3'(7 - slv_bit)];

    always @(negedge cs_n) if (rst_n) begin
        slv_bit = 0;
        slv_cur = resp_of(slv_k);
    end

    always @(negedge sclk) if (rst_n) begin
        slv_bit++;
        if (slv_bit == 8) begin
            slv_bit = 0;
            slv_k++;
            slv_cur = resp_of(slv_k);
        end
    end

    always @(posedge sclk) if (rst_n) begin
        cap_sh = {cap_sh[6:0], mosi};
        cap_cnt++;
        if (cap_cnt == 8) begin
            sent_mem[sent_n] = cap_sh;
            sent_n++;
            cap_cnt = 0;
        end
        if (last_rise >= 0) begin
            if (cyc - last_rise < gmin) gmin = cyc - last_rise;
            if (cyc - last_rise > gmax) gmax = cyc - last_rise;
        end
        last_rise = cyc;
    end

    always @(posedge cs_n) if (rst_n) begin
        cs_rises++;
        if (cap_cnt != 0) partial++;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic stats_reset();
        last_rise = -1;
        gmin = 1000000;
        gmax = 0;
    endtask

    task automatic host_write(input logic [7:0] b);
        int n = 0;
        while (!tx_empty && n < 5000) begin
            @(negedge clk);
            n++;
        end
        wr_data = b;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rx();
        int n = 0;
        while (!rx_full && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(rx_full == 1'b1, "R4", "rx_full timeout", int'(rx_full), 1);
    endtask

    task automatic host_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_release();
        cs_release = 1'b1;
        @(negedge clk);
        cs_release = 1'b0;
    endtask

    task automatic wait_not_busy();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (done == 0) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n0, r0, nb;
        logic [7:0] b;
        void'($urandom(32'd24681));
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
        chk(rx_full == 1'b0, "R1", "rx_full after reset", int'(rx_full), 0);
        chk(overrun == 1'b0, "R1", "overrun after reset", int'(overrun), 0);

        // R3 / R2 / R4 / R5: single byte, divider 1
        div_i = 8'd1;
        stats_reset();
        wr_data = 8'h05;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tx_empty == 1'b0, "R3", "tx_empty after accept", int'(tx_empty), 0);
        @(negedge clk);
        chk(tx_empty == 1'b1, "R3", "tx_empty after move to shifter", int'(tx_empty), 1);
        chk(cs_n == 1'b0, "R2", "cs_n low at start", int'(cs_n), 0);
        wait_rx();
        chk(rd_data == resp_of(e_k), "R4", "received byte", int'(rd_data), int'(resp_of(e_k)));
        chk(sent_mem[sent_n-1] == 8'h05, "R2", "byte on mosi", int'(sent_mem[sent_n-1]), 5);
        chk(gmin == 4 && gmax == 4, "R5", "rise spacing div1", gmax, 4);
        e_k++;
        host_read();
        chk(rx_full == 1'b0, "R4", "rx_full after read", int'(rx_full), 0);
        pulse_release();
        chk(cs_n == 1'b1, "R7", "idle release", int'(cs_n), 1);

        // R6: back-to-back bytes, divider 2
        div_i = 8'd2;
        stats_reset();
        r0 = cs_rises;
        n0 = sent_n;
        host_write(8'hA5);
        host_write(8'h3C);
        wait_rx();
        chk(rd_data == resp_of(e_k), "R6", "first of pair", int'(rd_data), int'(resp_of(e_k)));
        e_k++;
        host_read();
        wait_rx();
        chk(rd_data == resp_of(e_k), "R6", "second of pair", int'(rd_data), int'(resp_of(e_k)));
        e_k++;
        host_read();
        chk(sent_n == n0 + 2 && sent_mem[n0] == 8'hA5 && sent_mem[n0+1] == 8'h3C,
            "R6", "pair on mosi", int'(sent_mem[n0+1]), 8'h3C);
        chk(gmin == 6 && gmax == 6, "R6", "no idle clock across boundary", gmax, 6);
        chk(cs_rises == r0, "R6", "cs held across pair", cs_rises - r0, 0);
        pulse_release();

        // R10: write while full is ignored, divider 0
        div_i = 8'd0;
        n0 = sent_n;
        host_write(8'h11);
        host_write(8'h22);
        wr_data = 8'h99;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wait_rx();
        e_k++;
        host_read();
        wait_rx();
        e_k++;
        host_read();
        repeat (60) @(negedge clk);
        chk(sent_n == n0 + 2, "R10", "byte count", sent_n - n0, 2);
        chk(sent_mem[n0+1] == 8'h22, "R10", "held byte kept", int'(sent_mem[n0+1]), 8'h22);
        chk(rx_full == 1'b0, "R10", "no third reception", int'(rx_full), 0);
        pulse_release();

        // R7: release during a byte, divider 3
        div_i = 8'd3;
        n0 = sent_n;
        host_write(8'hC3);
        repeat (12) @(negedge clk);
        pulse_release();
        chk(cs_n == 1'b0 && busy == 1'b1, "R7", "cs held mid byte", int'(cs_n), 0);
        wait_not_busy();
        chk(cs_n == 1'b1, "R7", "cs raised at boundary", int'(cs_n), 1);
        chk(partial == 0, "R7", "no partial byte", partial, 0);
        chk(sent_n == n0 + 1 && sent_mem[n0] == 8'hC3, "R7", "byte completed",
            int'(sent_mem[n0]), 8'hC3);
        wait_rx();
        e_k++;
        host_read();

        // R8 / R9: overrun
        div_i = 8'd1;
        host_write(8'h5A);
        host_write(8'hE7);
        for (int i = 0; i < 5000 && !overrun; i++) @(negedge clk);
        chk(overrun == 1'b1, "R8", "overrun set", int'(overrun), 1);
        chk(rd_data == resp_of(e_k), "R8", "earlier byte kept", int'(rd_data), int'(resp_of(e_k)));
        e_k += 2;
        n0 = sent_n;
        host_write(8'h7E);
        repeat (200) @(negedge clk);
        chk(sent_n == n0, "R9", "no transfer during overrun", sent_n - n0, 0);
        chk(tx_empty == 1'b0, "R9", "byte held during overrun", int'(tx_empty), 0);
        chk(overrun == 1'b1, "R8", "overrun sticky", int'(overrun), 1);
        host_read();
        chk(overrun == 1'b1, "R8", "read does not clear overrun", int'(overrun), 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk(overrun == 1'b0, "R9", "clear input", int'(overrun), 0);
        wait_rx();
        chk(rd_data == resp_of(e_k), "R9", "held byte resumes", int'(rd_data), int'(resp_of(e_k)));
        chk(sent_mem[sent_n-1] == 8'h7E, "R9", "resumed byte on mosi",
            int'(sent_mem[sent_n-1]), 8'h7E);
        e_k++;
        host_read();
        pulse_release();
        wait_not_busy();

        // random divider and data
        for (int it = 0; it < 30; it++) begin
            div_i = 8'($urandom % 5);
            nb = 1 + int'($urandom % 3);
            for (int j = 0; j < nb; j++) begin
                b = 8'($urandom);
                stats_reset();
                host_write(b);
                wait_rx();
                chk(rd_data == resp_of(e_k), "R4", "random received",
                    int'(rd_data), int'(resp_of(e_k)));
                chk(sent_mem[sent_n-1] == b, "R2", "random sent", int'(sent_mem[sent_n-1]), int'(b));
                chk(gmin == 2 * (int'(div_i) + 1) && gmax == gmin, "R5", "random spacing",
                    gmax, 2 * (int'(div_i) + 1));
                e_k++;
                host_read();
            end
            pulse_release();
            wait_not_busy();
            @(negedge clk);
            chk(cs_n == 1'b1, "R1", "idle after group", int'(cs_n), 1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule